// File: doc/BRIEF.md
# Accumulating Shift Bit-Logic Unit

This execution unit owns a file of sixteen 32-bit data registers and carries out one family of single-bit instructions. Each instruction picks one bit out of a first source register and one bit out of a second source register, each at its own 5-bit position. It merges the two bits with one of eight two-input logic functions. It then moves the destination register up by one place and drops the merged bit into its least significant position.

Issuing a run of these instructions against the same destination therefore gathers a bit vector one bit per cycle, with the oldest result ending up highest. Every legal instruction completes in the clock cycle in which it is presented. A preload and readback port lets a test environment seed and inspect any register.

Top module: `bitacc_unit`

## Requirements
- R1: When a legal instruction executes, bits [31:1] of the destination register become the old bits [30:0], and the old bit 31 is lost.
- R2: The logic result of an executed instruction is written into bit 0 of the destination register, and the new value is visible on readback after the same clock edge.
- R3: The instruction word fields are: destination index [31:28], second position [27:23], function select [22:21], first position [20:16], second source index [15:12], first source index [11:8], major opcode [7:0]. The operand bits are bit (first position) of the first source and bit (second position) of the second source, with the two positions chosen independently.
- R4: The function is chosen by major opcode / select: 0x27/0 AND, 0x27/1 XOR, 0x27/2 NOR, 0x27/3 AND with the second bit inverted, 0xA7/0 NAND, 0xA7/1 OR, 0xA7/2 XNOR, 0xA7/3 OR with the second bit inverted.
- R5: For the two inverted-operand functions, only the bit taken from the second source is complemented. The bit from the first source is used as read.
- R6: A valid instruction whose major opcode is neither 0x27 nor 0xA7 changes no register, and it drives the illegal flag high during the following cycle only.
- R7: Source bits are read from register values as they were before the update, even when the destination index equals either source index.
- R8: A synchronous reset clears all sixteen registers and the illegal flag to zero.
- R9: The test write port loads a register only in a cycle with no valid instruction. In a cycle with a valid instruction, the test write is ignored.
- R10: Thirty-two successive instructions that target one destination leave it holding exactly those 32 results, with the first result in bit 31 and the last in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| tw_en | input | 1 | Test write enable |
| tw_idx | input | 4 | Test write register index |
| tw_data | input | 32 | Test write data |
| rd_idx | input | 4 | Readback register index |
| rd_data | output | 32 | Readback data, combinational from the register file |
| illegal_o | output | 1 | High for one cycle after an unrecognised instruction |

## Verification
Some properties are checked on every cycle. After each executed instruction, the destination's upper 31 bits must be its old lower 31 bits, and its bit 0 must equal the combiner's output. A cycle that follows an illegal instruction must leave the whole file stable. A test write issued alongside an instruction must not touch its target, unless that target is also the instruction's destination. The decoder only accepts the two major opcodes, and the inverted-operand functions behave as specified for a zero first bit.

Some behaviour can only be shown by the bench's scenarios. The full truth table of all eight encodings under both operand values must be exercised. The bench must also check position selection at non-trivial offsets and the aliasing of destination with sources. Finally, it confirms the 32-step accumulation order against an independently computed vector.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;

    localparam int DATA_W  = 32;
    localparam int NREG    = 16;
    localparam int IDX_W   = $clog2(NREG);
    localparam int POS_W   = $clog2(DATA_W);
    localparam int INSTR_W = 32;

    // field placement inside the instruction word
    localparam int F_DST_LO  = 28;
    localparam int F_POSB_LO = 23;
    localparam int F_SEL_LO  = 21;
    localparam int F_POSA_LO = 16;
    localparam int F_SRCB_LO = 12;
    localparam int F_SRCA_LO = 8;
    localparam int F_MAJ_LO  = 0;

    localparam logic [7:0] MAJ_LO = 8'h27;
    localparam logic [7:0] MAJ_HI = 8'hA7;

    localparam logic [1:0] SEL_LO_AND  = 2'd0;
    localparam logic [1:0] SEL_LO_XOR  = 2'd1;
    localparam logic [1:0] SEL_LO_NOR  = 2'd2;
    localparam logic [1:0] SEL_LO_ANDI = 2'd3;
    localparam logic [1:0] SEL_HI_NAND = 2'd0;
    localparam logic [1:0] SEL_HI_OR   = 2'd1;
    localparam logic [1:0] SEL_HI_XNOR = 2'd2;
    localparam logic [1:0] SEL_HI_ORI  = 2'd3;

    typedef enum logic [2:0] {
        FN_AND, FN_ANDI, FN_NAND, FN_NOR, FN_OR, FN_ORI, FN_XNOR, FN_XOR
    } bfunc_e;

    typedef struct packed {
        logic [IDX_W-1:0] dst;
        logic [POS_W-1:0] pos_b;
        logic [1:0]       sel;
        logic [POS_W-1:0] pos_a;
        logic [IDX_W-1:0] src_b;
        logic [IDX_W-1:0] src_a;
        logic [7:0]       major;
    } ifields_t;

endpackage

// File: rtl/bitacc_decode.sv
module bitacc_decode
    import bitacc_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output ifields_t           fld_o,
    output bfunc_e             func_o,
    output logic               legal_o
);
    always_comb begin
        fld_o.dst   = word_i[F_DST_LO  +: IDX_W];
        fld_o.pos_b = word_i[F_POSB_LO +: POS_W];
        fld_o.sel   = word_i[F_SEL_LO  +: 2];
        fld_o.pos_a = word_i[F_POSA_LO +: POS_W];
        fld_o.src_b = word_i[F_SRCB_LO +: IDX_W];
        fld_o.src_a = word_i[F_SRCA_LO +: IDX_W];
        fld_o.major = word_i[F_MAJ_LO  +: 8];
    end

    always_comb begin
        func_o  = FN_AND;
        legal_o = 1'b1;
        if (fld_o.major == MAJ_LO) begin
            unique case (fld_o.sel)
                SEL_LO_AND:  func_o = FN_AND;
                SEL_LO_XOR:  func_o = FN_XOR;
                SEL_LO_NOR:  func_o = FN_NOR;
                default:     func_o = FN_ANDI;
            endcase
        end else if (fld_o.major == MAJ_HI) begin
            unique case (fld_o.sel)
                SEL_HI_NAND: func_o = FN_NAND;
                SEL_HI_OR:   func_o = FN_OR;
                SEL_HI_XNOR: func_o = FN_XNOR;
                default:     func_o = FN_ORI;
            endcase
        end else begin
            legal_o = 1'b0;
        end
    end

    always_comb begin
        AST_LEGAL_MAJOR: assert (!legal_o || fld_o.major == MAJ_LO || fld_o.major == MAJ_HI); // R6
    end
endmodule

// File: rtl/bitacc_combine.sv
module bitacc_combine
    import bitacc_pkg::*;
(
    input  bfunc_e func_i,
    input  logic   a_i,
    input  logic   b_i,
    output logic   res_o
);
    always_comb begin
        unique case (func_i)
            FN_AND:  res_o =   a_i &  b_i;
            FN_ANDI: res_o =   a_i & ~b_i;
            FN_NAND: res_o = ~(a_i &  b_i);
            FN_NOR:  res_o = ~(a_i |  b_i);
            FN_OR:   res_o =   a_i |  b_i;
            FN_ORI:  res_o =   a_i | ~b_i;
            FN_XNOR: res_o = ~(a_i ^  b_i);
            default: res_o =   a_i ^  b_i;
        endcase
    end

    always_comb begin
        if (func_i == FN_ANDI && !a_i)
            AST_ANDI_ZERO: assert (!res_o); // R5
        if (func_i == FN_ORI && !a_i)
            AST_ORI_INV: assert (res_o == !b_i); // R5
    end
endmodule

// File: rtl/bitacc_unit.sv
module bitacc_unit
    import bitacc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               tw_en,
    input  logic [IDX_W-1:0]   tw_idx,
    input  logic [DATA_W-1:0]  tw_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic               illegal_o
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] file;
        logic                        illegal;
    } state_t;

    state_t st_q, st_d;

    ifields_t          fld;
    bfunc_e            func;
    logic              legal;
    logic              bit_a, bit_b, res_bit;
    logic              exec_w;
    logic [DATA_W-1:0] dst_old;

    bitacc_decode u_dec (
        .word_i  (instr_word),
        .fld_o   (fld),
        .func_o  (func),
        .legal_o (legal)
    );

    // operand bits come from pre-update register values (R7)
    assign bit_a   = st_q.file[fld.src_a][fld.pos_a];
    assign bit_b   = st_q.file[fld.src_b][fld.pos_b];
    assign dst_old = st_q.file[fld.dst];
    assign exec_w  = instr_valid && legal && !rst;

    bitacc_combine u_cmb (
        .func_i (func),
        .a_i    (bit_a),
        .b_i    (bit_b),
        .res_o  (res_bit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        if (instr_valid) begin
            if (legal)
                st_d.file[fld.dst] = {dst_old[DATA_W-2:0], res_bit};
            else
                st_d.illegal = 1'b1;
        end else if (tw_en) begin
            st_d.file[tw_idx] = tw_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_data   = st_q.file[rd_idx];
    assign illegal_o = st_q.illegal;

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
        $past(exec_w) |-> st_q.file[$past(fld.dst)][DATA_W-1:1] == $past(dst_old[DATA_W-2:0])); // R1
    AST_LSB_RESULT: assert property (@(posedge clk) disable iff (rst)
        $past(exec_w) |-> st_q.file[$past(fld.dst)][0] == $past(res_bit)); // R2
    AST_ILLEGAL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(st_q.file)); // R6
    AST_TW_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        ($past(tw_en && instr_valid && !rst) && $past(tw_idx) != $past(fld.dst))
        |-> st_q.file[$past(tw_idx)] == $past(st_q.file[tw_idx])); // R9
endmodule

// File: tb/bitacc_unit_bench.sv
module bitacc_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic        tw_en;
    logic [3:0]  tw_idx;
    logic [31:0] tw_data;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        illegal_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bitacc_unit u_bitacc_unit (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .illegal_o(illegal_o)
    );

    // function order: 0 AND,1 ANDI,2 NAND,3 NOR,4 OR,5 ORI,6 XNOR,7 XOR
    function automatic logic [7:0] maj_of(int f);
        case (f)
            0, 1, 3, 7: return 8'h27;
            default:    return 8'hA7;
        endcase
    endfunction

    function automatic logic [1:0] sel_of(int f);
        case (f)
            0: return 2'd0; 7: return 2'd1; 3: return 2'd2; 1: return 2'd3;
            2: return 2'd0; 4: return 2'd1; 6: return 2'd2; default: return 2'd3;
        endcase
    endfunction

    function automatic logic model(int f, logic a, logic b);
        case (f)
            0: return a & b;
            1: return a & !b;
            2: return !(a & b);
            3: return !(a | b);
            4: return a | b;
            5: return a | !b;
            6: return a == b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic logic [31:0] enc(logic [7:0] maj, logic [1:0] sel, logic [3:0] c,
                                        logic [3:0] a, logic [4:0] pa, logic [3:0] b, logic [4:0] pb);
        return {c, pb, sel, pa, b, a, maj};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [3:0] idx, logic [31:0] d);
        tw_en = 1'b1; tw_idx = idx; tw_data = d;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] idx, output logic [31:0] v);
        rd_idx = idx; #0.5; v = rd_data;
    endtask

    task automatic issue(logic [31:0] w);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        load(4'd3, 32'hDEAD_BEEF);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            rd(i[3:0], v);
            check("R8 reg cleared", v, 32'h0);
        end
        check("R8 flag cleared", {31'h0, illegal_o}, 32'h0);
    endtask

    task automatic t_truth();
        logic [31:0] v;
        logic [31:0] base;
        base = 32'hA5A5_0F0F;
        for (int f = 0; f < 8; f++)
            for (int k = 0; k < 4; k++) begin
                logic xa, xb;
                xa = k[1]; xb = k[0];
                load(4'd1, {26'h0, xa, 5'h0} | (~(32'h1 << 5) & 32'h5555_0000));
                load(4'd2, ({31'h0, xb} << 17) | (~(32'h1 << 17) & 32'h0000_AAAA));
                load(4'd3, base);
                issue(enc(maj_of(f), sel_of(f), 4'd3, 4'd1, 5'd5, 4'd2, 5'd17));
                rd(4'd3, v);
                // R1 R2 R3 R4 R5
                check($sformatf("R4 func %0d a=%0b b=%0b", f, xa, xb), v,
                      {base[30:0], model(f, xa, xb)});
            end
    endtask

    task automatic t_alias();
        logic [31:0] v;
        load(4'd10, 32'h8000_0001);
        issue(enc(8'h27, 2'd0, 4'd10, 4'd10, 5'd31, 4'd10, 5'd0));
        rd(4'd10, v);
        check("R7 alias AND old bits", v, 32'h0000_0003);
        load(4'd11, 32'h0000_0001);
        issue(enc(8'hA7, 2'd3, 4'd11, 4'd12, 5'd0, 4'd11, 5'd0));
        rd(4'd11, v);
        check("R7 R5 alias ORI second inverted", v, 32'h0000_0002);
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        load(4'd7, 32'h1234_5678);
        issue(enc(8'h13, 2'd0, 4'd7, 4'd7, 5'd0, 4'd7, 5'd0));
        rd(4'd7, v);
        check("R6 reg unchanged", v, 32'h1234_5678);
        check("R6 flag high", {31'h0, illegal_o}, 32'h1);
        @(negedge clk);
        check("R6 flag one cycle", {31'h0, illegal_o}, 32'h0);
        issue(enc(8'h27, 2'd1, 4'd7, 4'd7, 5'd0, 4'd7, 5'd1));
        check("R6 legal no flag", {31'h0, illegal_o}, 32'h0);
    endtask

    task automatic t_testwrite();
        logic [31:0] v;
        load(4'd9, 32'hCAFE_0000);
        rd(4'd9, v);
        check("R9 idle write lands", v, 32'hCAFE_0000);
        load(4'd8, 32'h0);
        tw_en = 1'b1; tw_idx = 4'd9; tw_data = 32'h0BAD_0BAD;
        issue(enc(8'hA7, 2'd0, 4'd8, 4'd0, 5'd0, 4'd0, 5'd0));
        tw_en = 1'b0;
        rd(4'd9, v);
        check("R9 write ignored", v, 32'hCAFE_0000);
        rd(4'd8, v);
        check("R9 instruction still ran", v, 32'h1);
    endtask

    task automatic t_accum();
        logic [31:0] v, exp, pa, pb;
        pa = 32'h9E37_79B9; pb = 32'h7F4A_7C15;
        load(4'd5, pa); load(4'd6, pb); load(4'd4, 32'hFFFF_FFFF);
        exp = 32'h0;
        for (int i = 0; i < 32; i++) begin
            issue(enc(8'h27, 2'd1, 4'd4, 4'd5, i[4:0], 4'd6, 5'(31 - i)));
            exp = {exp[30:0], pa[i] ^ pb[31 - i]};
        end
        rd(4'd4, v);
        check("R10 32-step vector", v, exp);
        check("R10 first result in bit31", {31'h0, v[31]}, {31'h0, pa[0] ^ pb[31]});
    endtask

    initial begin
        int cyc = 0;
        fork
            begin
                while (cyc < 100000) begin @(posedge clk); cyc++; end
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        join_none
    end

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
        tw_en = 1'b0; tw_idx = '0; tw_data = '0; rd_idx = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_truth();
        t_alias();
        t_illegal();
        t_testwrite();
        t_accum();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule